// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries two single-word messages between two ports that run on unrelated clocks. The first mailbox is loaded from port A and drained by port B. The second mailbox is loaded from port B and drained by port A. Each mailbox has an active-low "mail waiting" flag. The writer's clock sets the flag and the reader's clock clears it. Each port sees its own copy of that flag, kept in its own clock domain.

Each port has a chip select (active low), an enable and a direction select. The block decodes these into load and drain strobes. On port A a high direction select means write. On port B a low direction select means write. Port B's read bus is steered between the first mailbox and an external queue data input, under control of that port's mailbox select. Port A's read bus always presents the second mailbox. Pad drivers are not part of the block. Each port instead produces an output-enable for its data bus.

The flags cross between the clock domains by toggle handshakes. The writer flips a toggle bit for each new message. The reader flips its own toggle bit when it drains the message. Each toggle reaches the other domain through a two-flop synchronizer. A side sees mail pending when the writer toggle and the reader toggle differ in its own view.

Top module: `mbox_pair`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, all four flag outputs are high (no mail) and both output-enables are low while the chip selects are high.
- R2: A port-A operation with chip select low, enable high, direction high and mailbox select high stores the port-A data in mailbox 1. The port-A view of the mailbox-1 flag is low after that clkA rising edge.
- R3: After a mailbox-1 write, the port-B view of the mailbox-1 flag goes low no later than the third clkB rising edge.
- R4: A port-B operation with chip select low, enable high, direction high (read) and mailbox select high, made while the port-B view of the mailbox-1 flag is low, drives the port-B view high on that clkB edge. The port-A view goes high no later than the third clkA rising edge after it.
- R5: Mailbox 2 mirrors mailbox 1 with the ports swapped:
  - A port-B write (direction low, mailbox select high) stores the port-B data and lowers the port-B view on that clkB edge.
  - The port-A view goes low within three clkA edges.
  - A port-A read with mailbox select high lowers nothing and raises the port-A view on that clkA edge.
  - The port-B view then goes high within three clkB edges.
- R6: When chip select is high or enable is low on a rising edge, that port changes no mailbox content and no flag.
- R7: The direction encodings are as follows. On port A, 1 means write and 0 means read. On port B, 0 means write and 1 means read. An operation with the mailbox select low touches neither mailbox.
- R8: Port-B read data is mailbox 1 when the port-B mailbox select is high, and the queue data input when it is low. Port-A read data is mailbox 2.
- R9: Each port's output-enable is high exactly when its chip select is low and the port is in read mode. It does not depend on the enable.
- R10: A write to a mailbox whose flag is already low replaces the data and leaves the flag low. A single read then clears it.
- R11: A mailbox read while that mailbox's reader-side flag is high leaves both views of that flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port-A clock |
| clkB | input | 1 | Port-B clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| aCsN | input | 1 | Port-A chip select, active low |
| aEn | input | 1 | Port-A enable |
| aWr | input | 1 | Port-A direction, 1 = write |
| aMbx | input | 1 | Port-A mailbox select |
| aDin | input | DataW | Port-A write data |
| aDout | output | DataW | Port-A read data (mailbox 2) |
| aOe | output | 1 | Port-A data output-enable |
| bCsN | input | 1 | Port-B chip select, active low |
| bEn | input | 1 | Port-B enable |
| bWrN | input | 1 | Port-B direction, 0 = write |
| bMbx | input | 1 | Port-B mailbox select |
| bDin | input | DataW | Port-B write data |
| fifoDin | input | DataW | Queue data steered to port B when the mailbox select is low |
| bDout | output | DataW | Port-B read data |
| bOe | output | 1 | Port-B data output-enable |
| mb1FlagAN | output | 1 | Mailbox-1 mail-waiting flag, port-A view, active low |
| mb1FlagBN | output | 1 | Mailbox-1 mail-waiting flag, port-B view, active low |
| mb2FlagAN | output | 1 | Mailbox-2 mail-waiting flag, port-A view, active low |
| mb2FlagBN | output | 1 | Mailbox-2 mail-waiting flag, port-B view, active low |

## Verification
The assertions assume that a reader drains a mailbox only while its own view of that flag shows mail. They also assume that a writer does not reload a mailbox in the few cycles while a drain is still crossing to its side. Under those assumptions the toggle counts of each handshake never differ by more than one.

The stimulus keeps to this pattern for every case:
- One port acts at a time.
- After each load or drain, the bench waits at least three edges of the other clock before the next operation.
- The bench sweeps all sixteen combinations of chip select, enable, direction and mailbox select on each port.
- Both clocks run free at unrelated periods, so edge alignments vary across the sweep.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Strobes from the decode/handshake control to the data registers.
  typedef struct packed {
    logic loadMb1;   // clkA domain: capture port-A data into mailbox 1
    logic loadMb2;   // clkB domain: capture port-B data into mailbox 2
    logic pickMb1;   // port-B read mux: 1 = mailbox 1, 0 = queue input
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [Stages-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[Stages-2:0], d};
  end

  assign q = chain[Stages-1];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic         clkA,
  input  logic         clkB,
  input  logic         rstN,
  input  logic         aCsN,
  input  logic         aEn,
  input  logic         aWr,
  input  logic         aMbx,
  input  logic         bCsN,
  input  logic         bEn,
  input  logic         bWrN,
  input  logic         bMbx,
  output mboxStrobes_t strobes,
  output logic         aOe,
  output logic         bOe,
  output logic         mb1FlagAN,
  output logic         mb1FlagBN,
  output logic         mb2FlagAN,
  output logic         mb2FlagBN
);
  // Port decode
  logic aAct, bAct;
  logic wrMb1, rdMb2, wrMb2, rdMb1;

  assign aAct  = !aCsN && aEn;
  assign bAct  = !bCsN && bEn;
  assign wrMb1 = aAct && aWr && aMbx;
  assign rdMb2 = aAct && !aWr && aMbx;
  assign wrMb2 = bAct && !bWrN && bMbx;
  assign rdMb1 = bAct && bWrN && bMbx;

  assign aOe = !aCsN && !aWr;
  assign bOe = !bCsN && bWrN;

  // Toggle handshakes: mailbox 1 written in A, drained in B;
  // mailbox 2 written in B, drained in A.
  logic mb1WrTog, mb1RdTog, mb1WrTogB, mb1RdTogA;
  logic mb2WrTog, mb2RdTog, mb2WrTogA, mb2RdTogB;
  logic mb1FullA, mb1FullB, mb2FullA, mb2FullB;

  mbox_sync #(.Stages(SyncStages)) syncMb1Wr (.clk(clkB), .rstN(rstN), .d(mb1WrTog), .q(mb1WrTogB));
  mbox_sync #(.Stages(SyncStages)) syncMb1Rd (.clk(clkA), .rstN(rstN), .d(mb1RdTog), .q(mb1RdTogA));
  mbox_sync #(.Stages(SyncStages)) syncMb2Wr (.clk(clkA), .rstN(rstN), .d(mb2WrTog), .q(mb2WrTogA));
  mbox_sync #(.Stages(SyncStages)) syncMb2Rd (.clk(clkB), .rstN(rstN), .d(mb2RdTog), .q(mb2RdTogB));

  assign mb1FullA = mb1WrTog ^ mb1RdTogA;
  assign mb1FullB = mb1WrTogB ^ mb1RdTog;
  assign mb2FullB = mb2WrTog ^ mb2RdTogB;
  assign mb2FullA = mb2WrTogA ^ mb2RdTog;

  // Port-A clock domain
  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      mb1WrTog <= 1'b0;
      mb2RdTog <= 1'b0;
    end else begin
      if (wrMb1 && !mb1FullA) mb1WrTog <= !mb1WrTog;
      if (rdMb2 && mb2FullA)  mb2RdTog <= !mb2RdTog;
    end
  end

  // Port-B clock domain
  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      mb2WrTog <= 1'b0;
      mb1RdTog <= 1'b0;
    end else begin
      if (wrMb2 && !mb2FullB) mb2WrTog <= !mb2WrTog;
      if (rdMb1 && mb1FullB)  mb1RdTog <= !mb1RdTog;
    end
  end

  assign mb1FlagAN = !mb1FullA;
  assign mb1FlagBN = !mb1FullB;
  assign mb2FlagAN = !mb2FullA;
  assign mb2FlagBN = !mb2FullB;

  assign strobes.loadMb1 = wrMb1;
  assign strobes.loadMb2 = wrMb2;
  assign strobes.pickMb1 = bMbx;

  // R2
  mb1_set_chk: assert property (@(posedge clkA) disable iff (!rstN)
    wrMb1 && !mb1FullA |=> mb1FullA);
  // R4
  mb1_clear_chk: assert property (@(posedge clkB) disable iff (!rstN)
    rdMb1 && mb1FullB |=> !mb1FullB);
  // R5
  mb2_clear_chk: assert property (@(posedge clkA) disable iff (!rstN)
    rdMb2 && mb2FullA |=> !mb2FullA);
  // R6
  a_idle_chk: assert property (@(posedge clkA) disable iff (!rstN)
    !aAct |=> $stable(mb1WrTog) && $stable(mb2RdTog));
  // R6
  b_idle_chk: assert property (@(posedge clkB) disable iff (!rstN)
    !bAct |=> $stable(mb2WrTog) && $stable(mb1RdTog));
  // R10
  mb1_overwrite_chk: assert property (@(posedge clkA) disable iff (!rstN)
    wrMb1 && mb1FullA |=> $stable(mb1WrTog));
  // R11
  mb1_empty_read_chk: assert property (@(posedge clkB) disable iff (!rstN)
    rdMb1 && !mb1FullB |=> $stable(mb1RdTog));
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DataW = 36
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  mboxStrobes_t     strobes,
  input  logic [DataW-1:0] aDin,
  input  logic [DataW-1:0] bDin,
  input  logic [DataW-1:0] fifoDin,
  output logic [DataW-1:0] aDout,
  output logic [DataW-1:0] bDout
);
  logic [DataW-1:0] mb1Q, mb2Q;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)                mb1Q <= '0;
    else if (strobes.loadMb1) mb1Q <= aDin;
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)                mb2Q <= '0;
    else if (strobes.loadMb2) mb2Q <= bDin;
  end

  assign aDout = mb2Q;
  assign bDout = strobes.pickMb1 ? mb1Q : fifoDin;

  // R2
  mb1_load_chk: assert property (@(posedge clkA) disable iff (!rstN)
    strobes.loadMb1 |=> mb1Q == $past(aDin));
  // R6
  mb1_hold_chk: assert property (@(posedge clkA) disable iff (!rstN)
    !strobes.loadMb1 |=> $stable(mb1Q));
  // R5
  mb2_load_chk: assert property (@(posedge clkB) disable iff (!rstN)
    strobes.loadMb2 |=> mb2Q == $past(bDin));
  // R6
  mb2_hold_chk: assert property (@(posedge clkB) disable iff (!rstN)
    !strobes.loadMb2 |=> $stable(mb2Q));
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int DataW      = 36,
  parameter int SyncStages = 2
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  logic             aCsN,
  input  logic             aEn,
  input  logic             aWr,
  input  logic             aMbx,
  input  logic [DataW-1:0] aDin,
  output logic [DataW-1:0] aDout,
  output logic             aOe,
  input  logic             bCsN,
  input  logic             bEn,
  input  logic             bWrN,
  input  logic             bMbx,
  input  logic [DataW-1:0] bDin,
  input  logic [DataW-1:0] fifoDin,
  output logic [DataW-1:0] bDout,
  output logic             bOe,
  output logic             mb1FlagAN,
  output logic             mb1FlagBN,
  output logic             mb2FlagAN,
  output logic             mb2FlagBN
);
  mboxStrobes_t strobes;

  mbox_ctrl #(.SyncStages(SyncStages)) ctrl_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aCsN(aCsN), .aEn(aEn), .aWr(aWr), .aMbx(aMbx),
    .bCsN(bCsN), .bEn(bEn), .bWrN(bWrN), .bMbx(bMbx),
    .strobes(strobes), .aOe(aOe), .bOe(bOe),
    .mb1FlagAN(mb1FlagAN), .mb1FlagBN(mb1FlagBN),
    .mb2FlagAN(mb2FlagAN), .mb2FlagBN(mb2FlagBN)
  );

  mbox_datapath #(.DataW(DataW)) dp_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .strobes(strobes),
    .aDin(aDin), .bDin(bDin), .fifoDin(fifoDin),
    .aDout(aDout), .bDout(bDout)
  );
endmodule

// File: tb/mbox_pair_tb.sv
`timescale 1ns/1ps
module mbox_pair_tb_top;
  localparam int W = 36;

  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  logic aCsN = 1'b1, aEn = 1'b0, aWr = 1'b0, aMbx = 1'b0;
  logic bCsN = 1'b1, bEn = 1'b0, bWrN = 1'b1, bMbx = 1'b0;
  logic [W-1:0] aDin = '0, bDin = '0, fifoDin = '0;
  logic [W-1:0] aDout, bDout;
  logic aOe, bOe, mb1FlagAN, mb1FlagBN, mb2FlagAN, mb2FlagBN;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [W-1:0] mb1Exp = '0, mb2Exp = '0;

  always #2.5 clkA = !clkA;   // 200 MHz
  always #3.5 clkB = !clkB;

  mbox_pair dut_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aCsN(aCsN), .aEn(aEn), .aWr(aWr), .aMbx(aMbx), .aDin(aDin),
    .aDout(aDout), .aOe(aOe),
    .bCsN(bCsN), .bEn(bEn), .bWrN(bWrN), .bMbx(bMbx), .bDin(bDin),
    .fifoDin(fifoDin), .bDout(bDout), .bOe(bOe),
    .mb1FlagAN(mb1FlagAN), .mb1FlagBN(mb1FlagBN),
    .mb2FlagAN(mb2FlagAN), .mb2FlagBN(mb2FlagBN)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitA(input int n);
    repeat (n) @(posedge clkA);
    @(negedge clkA);
  endtask

  task automatic waitB(input int n);
    repeat (n) @(posedge clkB);
    @(negedge clkB);
  endtask

  // One port-A cycle; checks output-enable and read data while driven (R8, R9).
  task automatic opA(input logic csN, input logic en, input logic wr, input logic mbx, input logic [W-1:0] d);
    @(negedge clkA);
    aCsN = csN; aEn = en; aWr = wr; aMbx = mbx; aDin = d;
    #1;
    check(aOe == (!csN && !wr), "R9 aOe", W'(aOe), W'(!csN && !wr));
    if (aOe) check(aDout == mb2Exp, "R8 aDout", aDout, mb2Exp);
    @(posedge clkA);
    @(negedge clkA);
    aCsN = 1'b1; aEn = 1'b0;
  endtask

  task automatic opB(input logic csN, input logic en, input logic wrN, input logic mbx, input logic [W-1:0] d);
    logic [W-1:0] e;
    @(negedge clkB);
    bCsN = csN; bEn = en; bWrN = wrN; bMbx = mbx; bDin = d; fifoDin = ~d;
    #1;
    e = mbx ? mb1Exp : ~d;
    check(bOe == (!csN && wrN), "R9 bOe", W'(bOe), W'(!csN && wrN));
    if (bOe) check(bDout == e, "R8 bDout", bDout, e);
    @(posedge clkB);
    @(negedge clkB);
    bCsN = 1'b1; bEn = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clkB);
    // R1 during reset
    check({mb1FlagAN, mb1FlagBN, mb2FlagAN, mb2FlagBN} == 4'hF, "R1 flags in reset",
          W'({mb1FlagAN, mb1FlagBN, mb2FlagAN, mb2FlagBN}), W'(4'hF));
    @(negedge clkA);
    rstN = 1'b1;
    waitB(2);
    // R1 after reset
    check({mb1FlagAN, mb1FlagBN, mb2FlagAN, mb2FlagBN} == 4'hF, "R1 flags after reset",
          W'({mb1FlagAN, mb1FlagBN, mb2FlagAN, mb2FlagBN}), W'(4'hF));
    check({aOe, bOe} == 2'b00, "R1 oe idle", W'({aOe, bOe}), '0);

    // Port-A sweep: R2 R3 R4 R6 R7 R11
    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      logic [W-1:0] d;
      bit doWr;
      c = 4'(i);
      d = {4'hA, 32'(i) * 32'h01030507};
      doWr = !c[3] && c[2] && c[1] && c[0];
      opA(c[3], c[2], c[1], c[0], d);
      check(mb1FlagAN == !doWr, "R2/R6/R7 mb1 flag A", W'(mb1FlagAN), W'(!doWr));
      check(mb2FlagAN == 1'b1, "R11 mb2 flag A after empty read", W'(mb2FlagAN), W'(1));
      if (doWr) mb1Exp = d;
      waitB(3);
      check(mb1FlagBN == !doWr, "R3 mb1 flag B", W'(mb1FlagBN), W'(!doWr));
      opB(1'b0, 1'b1, 1'b1, 1'b1, d);
      check(mb1FlagBN == 1'b1, "R4/R11 mb1 flag B after read", W'(mb1FlagBN), W'(1));
      waitA(3);
      check(mb1FlagAN == 1'b1, "R4 mb1 flag A after read", W'(mb1FlagAN), W'(1));
      waitB(3);
      check(mb2FlagBN == 1'b1, "R11 mb2 flag B", W'(mb2FlagBN), W'(1));
    end

    // Port-B sweep: R5 R6 R7 R8 R11
    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      logic [W-1:0] d;
      bit doWr;
      c = 4'(i);
      d = {4'h5, 32'(i) * 32'h11020903};
      doWr = !c[3] && c[2] && !c[1] && c[0];
      opB(c[3], c[2], c[1], c[0], d);
      check(mb2FlagBN == !doWr, "R5/R6/R7 mb2 flag B", W'(mb2FlagBN), W'(!doWr));
      check(mb1FlagBN == 1'b1, "R11 mb1 flag B after empty read", W'(mb1FlagBN), W'(1));
      if (doWr) mb2Exp = d;
      waitA(3);
      check(mb2FlagAN == !doWr, "R5 mb2 flag A", W'(mb2FlagAN), W'(!doWr));
      opA(1'b0, 1'b1, 1'b0, 1'b1, d);
      check(mb2FlagAN == 1'b1, "R5 mb2 flag A after read", W'(mb2FlagAN), W'(1));
      waitB(3);
      check(mb2FlagBN == 1'b1, "R5 mb2 flag B after read", W'(mb2FlagBN), W'(1));
      waitA(3);
      check(mb1FlagAN == 1'b1, "R11 mb1 flag A", W'(mb1FlagAN), W'(1));
    end

    // R10: overwrite while pending
    opA(1'b0, 1'b1, 1'b1, 1'b1, 36'h1_2345_6789);
    mb1Exp = 36'h1_2345_6789;
    opA(1'b0, 1'b1, 1'b1, 1'b1, 36'h9_8765_4321);
    mb1Exp = 36'h9_8765_4321;
    check(mb1FlagAN == 1'b0, "R10 flag stays low", W'(mb1FlagAN), '0);
    waitB(3);
    check(mb1FlagBN == 1'b0, "R10 flag B low", W'(mb1FlagBN), '0);
    opB(1'b0, 1'b1, 1'b1, 1'b1, 36'h0);
    check(mb1FlagBN == 1'b1, "R10 one read clears", W'(mb1FlagBN), W'(1));
    waitA(3);
    check(mb1FlagAN == 1'b1, "R10 flag A clear", W'(mb1FlagAN), W'(1));
    opB(1'b0, 1'b1, 1'b1, 1'b1, 36'h0);
    waitA(3);
    check(mb1FlagAN == 1'b1 && mb1FlagBN == 1'b1, "R10/R11 no second message",
          W'({mb1FlagAN, mb1FlagBN}), W'(2'b11));

    // R8: queue path with mailbox select low, several patterns
    for (int k = 0; k < 4; k++) opB(1'b0, 1'b1, 1'b1, 1'b0, W'(36'hF_0F0F_0F0F >> k));

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule